// File: doc/BRIEF.md
# UART Transmit DMA Request Generator

This block decides when a UART transmitter asks a DMA engine for more characters. It watches the transmit FIFO occupancy, a flag that says whether the FIFO is in use, a flag that says the single holding register is empty, and an enable for programmable threshold operation. From these inputs and a small write-only control register, it drives an active-low request line. It also drives a threshold indication that the interrupt logic can use.

The control register holds two fields. The first is a two-bit selector that picks an empty threshold. The second is a one-bit transfer mode. In single-transfer mode the request follows a level condition. In multi-transfer mode with the threshold disabled, the request is asserted when the FIFO is empty and stays asserted until the FIFO is full, so a burst of writes can fill it. Both outputs are registered.

Top module: `uart_txdma_req`

## Requirements
- R1: The request output `dma_tx_req_n` is active low. While `rst_n` is low, `dma_tx_req_n` is 1 and `thre_hit` is 0.
- R2: The threshold selector maps to a character count. Selector 0 gives 0, selector 1 gives 2, selector 2 gives DEPTH/4 and selector 3 gives DEPTH/2.
- R3: On a rising clock edge with `cfg_wr` high, `cfg_wdata[1:0]` is stored as the threshold selector and `cfg_wdata[2]` as the transfer mode (0 = single, 1 = multi). When `cfg_wr` is low, `cfg_wdata` has no effect. The new setting governs the value that the outputs take at the following edge.
- R4: When `fifo_en` is 0, the request is asserted exactly when `thr_empty` is 1. This holds in both transfer modes.
- R5: In single mode with `fifo_en` = 1 and `prog_en` = 0, the request is asserted exactly when `fifo_level` is 0. It therefore releases as soon as one character is written.
- R6: With `fifo_en` = 1 and `prog_en` = 1, the request is asserted exactly when `fifo_level` is at or below the selected threshold count. This holds in both transfer modes.
- R7: In multi mode with `fifo_en` = 1 and `prog_en` = 0, the request asserts when `fifo_level` is 0 and releases when `fifo_level` equals DEPTH. At any other level it keeps its previous value.
- R8: `thre_hit` is 1 exactly when `fifo_en` and `prog_en` are both 1 and `fifo_level` is at or below the selected threshold count.
- R9: Both outputs are registered. Each one reflects the inputs and the control setting present at the previous rising edge.
- R10: Reset clears the control register to single mode with selector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control write data: [1:0] threshold selector, [2] transfer mode |
| fifo_en | input | 1 | 1 when the transmit FIFO is in use |
| thr_empty | input | 1 | Holding register empty (used when the FIFO is not in use) |
| prog_en | input | 1 | Programmable threshold operation enable |
| fifo_level | input | $clog2(DEPTH+1) | Transmit FIFO occupancy, 0 to DEPTH |
| dma_tx_req_n | output | 1 | Transmit DMA request, active low |
| thre_hit | output | 1 | Occupancy at or below the threshold while threshold operation is on |

## Verification
The assertions check the following rules on every cycle, each one against the inputs one edge earlier:
- the request follows the holding-register flag when the FIFO is not in use;
- in single mode without a threshold, the request is low exactly when the FIFO is empty;
- in threshold operation, the request matches the threshold comparison;
- the multi-mode request holds its value between the empty and full levels;
- a raised threshold indication always coincides with an asserted request.

Some behaviour can only be shown by the bench's scenarios:
- the selector-to-count mapping at each depth fraction;
- the write-only register ignoring data when no strobe is present;
- the two-edge delay from a control write to the request;
- the full release-and-refill cycle of multi mode as occupancy sweeps up to DEPTH and back.

// File: rtl/uart_txdma_pkg.sv
package uart_txdma_pkg;

  typedef enum logic {
    XFER_SINGLE = 1'b0,
    XFER_MULTI  = 1'b1
  } xfer_mode_e;

  // Character count selected by the two-bit threshold selector.
  function automatic int unsigned level_for_sel(input logic [1:0] sel,
                                                input int unsigned depth);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 2;
      2'd2:    return depth / 4;
      default: return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/uart_txdma_cfg.sv
module uart_txdma_cfg
  import uart_txdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] wdata,
  output logic [1:0] thr_sel,
  output xfer_mode_e mode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_sel <= 2'd0;
      mode    <= XFER_SINGLE;
    end else if (wr) begin
      thr_sel <= wdata[1:0];
      mode    <= xfer_mode_e'(wdata[2]);
    end
  end

endmodule

// File: rtl/uart_txdma_level.sv
module uart_txdma_level
  import uart_txdma_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] level,
  input  logic [1:0]    thr_sel,
  output logic [CW-1:0] thr_count,
  output logic          at_or_below,
  output logic          is_empty,
  output logic          is_full
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  assign thr_count   = CW'(level_for_sel(thr_sel, DEPTH));
  assign at_or_below = (level <= thr_count);
  assign is_empty    = (level == '0);
  assign is_full     = (level >= FULL_LVL);

endmodule

// File: rtl/uart_txdma_reqgen.sv
module uart_txdma_reqgen
  import uart_txdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  xfer_mode_e mode,
  input  logic       fifo_en,
  input  logic       thr_empty,
  input  logic       prog_en,
  input  logic       at_or_below,
  input  logic       is_empty,
  input  logic       is_full,
  output logic       req_q,
  output logic       hit_q
);

  logic req_d;
  logic hit_d;

  always_comb begin
    req_d = req_q;
    if (!fifo_en) begin
      req_d = thr_empty;
    end else if (prog_en) begin
      req_d = at_or_below;
    end else if (mode == XFER_SINGLE) begin
      req_d = is_empty;
    end else begin
      if (is_empty)     req_d = 1'b1;
      else if (is_full) req_d = 1'b0;
    end
    hit_d = fifo_en && prog_en && at_or_below;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      req_q <= req_d;
      hit_q <= hit_d;
    end
  end

endmodule

// File: rtl/uart_txdma_req.sv
module uart_txdma_req
  import uart_txdma_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_wdata,
  input  logic          fifo_en,
  input  logic          thr_empty,
  input  logic          prog_en,
  input  logic [CW-1:0] fifo_level,
  output logic          dma_tx_req_n,
  output logic          thre_hit
);

  logic [1:0]    cfg_thr_sel;
  xfer_mode_e    cfg_mode;
  logic [CW-1:0] thr_count;
  logic          lvl_at_or_below;
  logic          lvl_empty;
  logic          lvl_full;
  logic          req_active;

  uart_txdma_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .wdata   (cfg_wdata),
    .thr_sel (cfg_thr_sel),
    .mode    (cfg_mode)
  );

  uart_txdma_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .level       (fifo_level),
    .thr_sel     (cfg_thr_sel),
    .thr_count   (thr_count),
    .at_or_below (lvl_at_or_below),
    .is_empty    (lvl_empty),
    .is_full     (lvl_full)
  );

  uart_txdma_reqgen u_reqgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (cfg_mode),
    .fifo_en     (fifo_en),
    .thr_empty   (thr_empty),
    .prog_en     (prog_en),
    .at_or_below (lvl_at_or_below),
    .is_empty    (lvl_empty),
    .is_full     (lvl_full),
    .req_q       (req_active),
    .hit_q       (thre_hit)
  );

  assign dma_tx_req_n = ~req_active;

endmodule

// File: rtl/uart_txdma_req_chk.sv
module uart_txdma_req_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          thr_empty,
  input logic          prog_en,
  input logic          multi,
  input logic [CW-1:0] fifo_level,
  input logic [CW-1:0] thr_count,
  input logic          dma_tx_req_n,
  input logic          thre_hit
);

  assert_nofifo_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (dma_tx_req_n == !$past(thr_empty)));

  assert_single_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !prog_en && !multi) |=> (dma_tx_req_n == ($past(fifo_level) != '0)));

  assert_prog_threshold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && prog_en) |=> (dma_tx_req_n == ($past(fifo_level) > $past(thr_count))));

  assert_multi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !prog_en && multi && fifo_level != '0 && fifo_level != CW'(DEPTH))
      |=> $stable(dma_tx_req_n));

  assert_hit_implies_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    thre_hit |-> !dma_tx_req_n);

endmodule

bind uart_txdma_req uart_txdma_req_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_en      (fifo_en),
  .thr_empty    (thr_empty),
  .prog_en      (prog_en),
  .multi        (cfg_mode == uart_txdma_pkg::XFER_MULTI),
  .fifo_level   (fifo_level),
  .thr_count    (thr_count),
  .dma_tx_req_n (dma_tx_req_n),
  .thre_hit     (thre_hit)
);

// File: tb/test_uart_txdma_req.sv
module test_uart_txdma_req;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_wdata = 3'd0;
  logic fifo_en = 1'b0;
  logic thr_empty = 1'b0;
  logic prog_en = 1'b0;
  logic [CW-1:0] fifo_level = '0;
  logic dma_tx_req_n;
  logic thre_hit;

  int total = 0;
  int bad = 0;
  bit checking = 0;
  bit finished = 0;
  string tag = "R1";

  // reference state
  bit m_req = 0, m_hit = 0, m_multi = 0;
  int m_sel = 0;

  always #5 clk = ~clk;

  uart_txdma_req #(.DEPTH(DEPTH)) i_uart_txdma_req (
    .clk, .rst_n, .cfg_wr, .cfg_wdata, .fifo_en, .thr_empty, .prog_en,
    .fifo_level, .dma_tx_req_n, .thre_hit
  );

  function automatic int sel_count(int s);   // R2 mapping
    if (s == 0) return 0;
    if (s == 1) return 2;
    if (s == 2) return DEPTH / 4;
    return DEPTH / 2;
  endfunction

  // behavioural reference, advanced on each edge (R9: one-edge latency)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_hit = 0; m_multi = 0; m_sel = 0;   // R10
    end else begin
      int lv;
      int th;
      lv = int'(fifo_level);
      th = sel_count(m_sel);
      if (!fifo_en) m_req = thr_empty;
      else if (prog_en) m_req = (lv <= th);
      else if (!m_multi) m_req = (lv == 0);
      else if (lv == 0) m_req = 1;
      else if (lv == DEPTH) m_req = 0;
      m_hit = fifo_en && prog_en && (lv <= th);
      if (cfg_wr) begin
        m_sel = int'(cfg_wdata[1:0]);
        m_multi = cfg_wdata[2];
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      total++;
      if (dma_tx_req_n !== !m_req || thre_hit !== m_hit) begin
        bad++;
        $display("FAIL %s: req_n=%b hit=%b expected req_n=%b hit=%b (lvl=%0d)",
                 tag, dma_tx_req_n, thre_hit, !m_req, m_hit, fifo_level);
      end
    end
  end

  task automatic step(int lv, bit fe, bit te, bit pe);
    @(posedge clk); #2;
    cfg_wr = 0; fifo_level = CW'(lv); fifo_en = fe; thr_empty = te; prog_en = pe;
  endtask

  task automatic write_cfg(int sel, bit multi);
    @(posedge clk); #2;
    cfg_wr = 1; cfg_wdata = {multi, 2'(sel)};
    @(posedge clk); #2;
    cfg_wr = 0; cfg_wdata = ~cfg_wdata;   // no strobe: must be ignored (R3)
  endtask

  task automatic sweep(bit fe, bit pe);
    for (int v = 0; v <= DEPTH; v++) step(v, fe, 0, pe);
    step(DEPTH, fe, 0, pe);
    for (int v = DEPTH - 1; v >= 0; v--) step(v, fe, 0, pe);
    step(3, fe, 0, pe); step(DEPTH, fe, 0, pe); step(1, fe, 0, pe); step(0, fe, 0, pe);
  endtask

  task automatic reset_check();
    #1;
    total++;
    if (dma_tx_req_n !== 1'b1 || thre_hit !== 1'b0) begin
      bad++;
      $display("FAIL R1: req_n=%b hit=%b expected req_n=1 hit=0", dma_tx_req_n, thre_hit);
    end
  endtask

  initial begin
    #3 reset_check();
    #20;
    @(posedge clk); #2 rst_n = 1;
    checking = 1;
    // R10: power-up config is single mode, selector 0
    tag = "R10/R5"; sweep(1, 0);
    tag = "R10/R6"; sweep(1, 1);
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        write_cfg(s, m[0]);
        tag = "R4"; for (int k = 0; k < 6; k++) step(k, 0, k[0] ^ k[1], k[0]);
        tag = (m == 0) ? "R5" : "R7"; sweep(1, 0);
        tag = "R2/R6/R8"; sweep(1, 1);
      end
    end
    // R3: write takes effect at the next edge, unstrobed data ignored
    tag = "R3";
    write_cfg(3, 0);
    step(DEPTH / 2, 1, 0, 1); step(DEPTH / 2, 1, 0, 1);
    write_cfg(0, 0);
    step(DEPTH / 2, 1, 0, 1); step(0, 1, 0, 1); step(1, 1, 0, 1); step(1, 1, 0, 1);
    // R1/R10: asynchronous reset mid-run
    write_cfg(2, 1);
    step(0, 1, 0, 1); step(0, 1, 0, 1);
    @(posedge clk); #2 checking = 0; rst_n = 0;
    reset_check();
    @(posedge clk); #2 rst_n = 1; checking = 1;
    tag = "R10"; sweep(1, 0);
    checking = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule